// File: doc/BRIEF.md
# Self-Triggered Bunch-Crossing Hit Store

This block is the acquisition core of a front-end readout chip on a collider that delivers particles in trains of closely spaced bunch crossings. No trigger exists. On every bunch-crossing strobe inside a train, the block captures one digitised amplitude per pad. It compares each amplitude with a programmable threshold and keeps only the samples that exceed it. Each kept sample becomes a hit word that carries the crossing index and the pad number, and the word is written into a bounded on-chip memory.

After the train ends, a readout request drains the memory as a word stream under a valid/ready handshake. The stream starts with a header that holds the hit count, continues with one word per hit, and ends with a trailer that reports whether hits were lost to a full memory. Draining happens in the long gap between trains. A train-start strobe that arrives while a drain is running is flagged as a sequencing error and has no other effect.

Top module: `sthit_store`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` and `seq_err` are low.
- R2: A pad sample is kept only when it is strictly greater than `thresh`. A sample equal to or below the threshold produces no hit word.
- R3: Hits leave the block in the order they were captured: crossings in time order, and within one crossing in ascending pad number. Each hit word carries bunch index in bits [23:12], pad number in bits [11:10] and amplitude in bits [9:0] (default widths).
- R4: The bunch index is 0 for the first crossing after an accepted train start and rises by one on each later crossing of that train. Crossing strobes outside a train are ignored and do not advance the index.
- R5: The stream word's kind sits in bits [25:24]. Code 01 is the header, whose low bits hold the hit count. Code 00 is a hit. Code 11 is the trailer, whose bit 0 is the overflow flag. The stream is always header, then the hits, then the trailer.
- R6: `rd_req` starts a drain only after a train has ended and the pad scan is idle. During a train it is ignored and `out_valid` stays low.
- R7: A train stores at most DEPTH hits. Later hits are dropped, the header count equals DEPTH, and the trailer overflow bit is 1.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values until the word is accepted.
- R9: `train_start` during a drain raises `seq_err` for one cycle on the next cycle. The stream still completes unchanged, and the block then returns to idle with the new train not started.
- R10: An accepted train start clears the stored hits and the overflow flag, so the next stream reports only the new train.
- R11: A train with no hits is drained as a header with count 0, directly followed by the trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| train_start | input | 1 | One-cycle strobe that opens a train |
| train_stop | input | 1 | One-cycle strobe that closes a train |
| bx_strobe | input | 1 | One-cycle strobe per bunch crossing |
| pad_amps | input | NPADS*AMP_W | Packed pad amplitudes, pad 0 in the low bits |
| thresh | input | AMP_W | Keep threshold (strictly greater than) |
| rd_req | input | 1 | Request to drain the stored hits |
| out_ready | input | 1 | Consumer accepts the current stream word |
| out_valid | output | 1 | Stream word present |
| out_data | output | 2+BX_W+PAD_W+AMP_W | Stream word: kind and payload |
| seq_err | output | 1 | One-cycle pulse for a train start during a drain |

## Verification
The assertions assume that crossing strobes inside a train are spaced at least NPADS+1 cycles apart, so the pad scan of one crossing finishes before the next crossing is captured. They also assume that `train_start` and `bx_strobe` never coincide. The stimulus places crossings eight cycles apart and waits several cycles after the last crossing before it closes a train or requests a drain. It drives every input one time unit after a rising edge and holds it for exactly one edge, so each strobe is seen once.

// File: rtl/sthit_pkg.sv
// Shared encodings for the bunch-crossing hit store.
// Assumes: kind codes are decoded by the downstream serialiser, so their
// values are fixed.
package sthit_pkg;
    typedef enum logic [1:0] {
        KIND_HIT = 2'b00,
        KIND_HDR = 2'b01,
        KIND_TRL = 2'b11
    } word_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACQ,
        PH_HOLD,
        PH_HDR,
        PH_BODY,
        PH_TRL
    } phase_e;
endpackage

// File: rtl/sthit_scan.sv
// Pad scanner: on a start pulse it captures all pad amplitudes, the
// threshold and the bunch index. It then walks the pads one per cycle and
// offers each above-threshold sample as a tagged hit word.
// Assumes: start does not arrive while busy (crossing spacing > NPADS).
module sthit_scan #(
    parameter int NPADS = 4,
    parameter int AMP_W = 10,
    parameter int BX_W  = 12,
    parameter int PAD_W = 2,
    localparam int HIT_W = BX_W + PAD_W + AMP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NPADS*AMP_W-1:0] amps_in,
    input  logic [AMP_W-1:0]       thresh,
    input  logic [BX_W-1:0]        bx_in,
    output logic                   busy,
    output logic                   hit_vld,
    output logic [HIT_W-1:0]       hit_word
);
    logic [NPADS-1:0][AMP_W-1:0] amp_q;
    logic [AMP_W-1:0]            thr_q;
    logic [BX_W-1:0]             bx_q;
    logic [PAD_W-1:0]            idx_q;
    logic [AMP_W-1:0]            cur_amp;

    // Capture the crossing snapshot on start.
    always_ff @(posedge clk) begin
        if (start) begin
            amp_q <= amps_in;
            thr_q <= thresh;
            bx_q  <= bx_in;
        end
    end

    // Step through the pads, dropping busy after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            idx_q <= '0;
        end else if (busy) begin
            if (idx_q == PAD_W'(NPADS - 1)) busy <= 1'b0;
            idx_q <= idx_q + PAD_W'(1);
        end
    end

    // Compare the current pad against the captured threshold.
    always_comb begin
        cur_amp  = amp_q[idx_q];
        hit_vld  = busy && (cur_amp > thr_q);
        hit_word = {bx_q, idx_q, cur_amp};
    end
endmodule

// File: rtl/sthit_mem.sv
// Hit memory: appends hit words at the fill count. Once full it drops
// further writes and sets a sticky overflow flag. Reading is combinational
// by address.
// Assumes: clear and wr_en are never high together (the scan is idle at
// a train start).
module sthit_mem #(
    parameter int DEPTH = 64,
    parameter int HIT_W = 24,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [HIT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HIT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);
    logic [HIT_W-1:0] store_q [DEPTH];
    logic             has_room;

    assign has_room = (count < CNT_W'(DEPTH));

    // Write the next free slot.
    always_ff @(posedge clk) begin
        if (wr_en && has_room) store_q[count[ADDR_W-1:0]] <= wr_data;
    end

    // Track the fill level and the sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (wr_en) begin
            if (has_room) count <= count + CNT_W'(1);
            else          ovf   <= 1'b1;
        end
    end

    // Read port for the drain.
    assign rd_data = store_q[rd_addr];
endmodule

// File: rtl/sthit_ctrl.sv
// Phase controller: runs train acquisition, the bunch counter, drain
// sequencing (header, hits, trailer) and the sequencing-error pulse.
// Assumes: train_start and bx_strobe are single-cycle strobes.
module sthit_ctrl
    import sthit_pkg::*;
#(
    parameter int BX_W   = 12,
    parameter int HIT_W  = 24,
    parameter int CNT_W  = 7,
    parameter int ADDR_W = 6,
    localparam int WORD_W = 2 + HIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_start,
    input  logic              train_stop,
    input  logic              bx_strobe,
    input  logic              rd_req,
    input  logic              out_ready,
    input  logic              scan_busy,
    input  logic [CNT_W-1:0]  hit_count,
    input  logic              ovf,
    input  logic [HIT_W-1:0]  rd_data,
    output logic              clear,
    output logic              scan_start,
    output logic [BX_W-1:0]   bx_now,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              acq,
    output logic              draining,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              seq_err
);
    phase_e            ph_q, ph_nx;
    logic [BX_W-1:0]   bx_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              last_hit;

    // Decode phase-level controls.
    always_comb begin
        acq        = (ph_q == PH_ACQ);
        draining   = (ph_q == PH_HDR) || (ph_q == PH_BODY) || (ph_q == PH_TRL);
        clear      = train_start && ((ph_q == PH_IDLE) || (ph_q == PH_HOLD));
        scan_start = acq && bx_strobe;
        last_hit   = (CNT_W'(ptr_q) == hit_count - CNT_W'(1));
    end

    // Next-phase selection.
    always_comb begin
        ph_nx = ph_q;
        unique case (ph_q)
            PH_IDLE: if (train_start) ph_nx = PH_ACQ;
            PH_ACQ:  if (train_stop)  ph_nx = PH_HOLD;
            PH_HOLD: begin
                if (train_start)               ph_nx = PH_ACQ;
                else if (rd_req && !scan_busy) ph_nx = PH_HDR;
            end
            PH_HDR:  if (out_ready) ph_nx = (hit_count == '0) ? PH_TRL : PH_BODY;
            PH_BODY: if (out_ready && last_hit) ph_nx = PH_TRL;
            PH_TRL:  if (out_ready) ph_nx = PH_IDLE;
            default: ph_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_nx;
    end

    // Bunch counter: cleared at train start, counts crossings, saturates.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                 bx_q <= '0;
        else if (scan_start && !(&bx_q))     bx_q <= bx_q + BX_W'(1);
    end

    // Drain read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || ph_q == PH_HDR)        ptr_q <= '0;
        else if (ph_q == PH_BODY && out_ready) ptr_q <= ptr_q + ADDR_W'(1);
    end

    // Sequencing error: a train start arriving mid-drain.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_err <= 1'b0;
        else        seq_err <= train_start && draining;
    end

    // Stream word assembly.
    always_comb begin
        bx_now    = bx_q;
        rd_addr   = ptr_q;
        out_valid = draining;
        unique case (ph_q)
            PH_HDR:  out_data = {KIND_HDR, HIT_W'(hit_count)};
            PH_BODY: out_data = {KIND_HIT, rd_data};
            PH_TRL:  out_data = {KIND_TRL, HIT_W'(ovf)};
            default: out_data = '0;
        endcase
    end
endmodule

// File: rtl/sthit_store.sv
// Top level of the self-triggered hit store: ties the pad scanner, the hit
// memory and the phase controller together.
// Assumes: in-train crossings are at least NPADS+1 cycles apart.
module sthit_store #(
    parameter int NPADS = 4,
    parameter int AMP_W = 10,
    parameter int BX_W  = 12,
    parameter int DEPTH = 64,
    localparam int PAD_W  = (NPADS > 1) ? $clog2(NPADS) : 1,
    localparam int HIT_W  = BX_W + PAD_W + AMP_W,
    localparam int WORD_W = 2 + HIT_W,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   train_start,
    input  logic                   train_stop,
    input  logic                   bx_strobe,
    input  logic [NPADS*AMP_W-1:0] pad_amps,
    input  logic [AMP_W-1:0]       thresh,
    input  logic                   rd_req,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [WORD_W-1:0]      out_data,
    output logic                   seq_err
);
    logic              clear, scan_start, scan_busy, hit_vld;
    logic [HIT_W-1:0]  hit_word, rd_data;
    logic [BX_W-1:0]   bx_cnt;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  hit_count;
    logic              ovf_flag, acq, draining;

    sthit_scan #(
        .NPADS(NPADS), .AMP_W(AMP_W), .BX_W(BX_W), .PAD_W(PAD_W)
    ) i_scan (
        .clk(clk), .rst_n(rst_n), .start(scan_start), .amps_in(pad_amps),
        .thresh(thresh), .bx_in(bx_cnt), .busy(scan_busy),
        .hit_vld(hit_vld), .hit_word(hit_word)
    );

    sthit_mem #(
        .DEPTH(DEPTH), .HIT_W(HIT_W)
    ) i_mem (
        .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(hit_vld),
        .wr_data(hit_word), .rd_addr(rd_addr), .rd_data(rd_data),
        .count(hit_count), .ovf(ovf_flag)
    );

    sthit_ctrl #(
        .BX_W(BX_W), .HIT_W(HIT_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .train_start(train_start),
        .train_stop(train_stop), .bx_strobe(bx_strobe), .rd_req(rd_req),
        .out_ready(out_ready), .scan_busy(scan_busy), .hit_count(hit_count),
        .ovf(ovf_flag), .rd_data(rd_data), .clear(clear),
        .scan_start(scan_start), .bx_now(bx_cnt), .rd_addr(rd_addr),
        .acq(acq), .draining(draining), .out_valid(out_valid),
        .out_data(out_data), .seq_err(seq_err)
    );
endmodule

// File: rtl/sthit_store_chk.sv
// Property checker for sthit_store, attached by bind.
// Assumes: the input rules listed in the brief.
module sthit_store_chk #(
    parameter int DEPTH  = 64,
    parameter int BX_W   = 12,
    parameter int WORD_W = 26,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              train_start,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              seq_err,
    input logic [CNT_W-1:0]  hit_count,
    input logic              ovf_flag,
    input logic              acq,
    input logic              draining,
    input logic [BX_W-1:0]   bx_cnt
);
    a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    a_r5_header_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_data[WORD_W-1 -: 2] == 2'b01);

    a_r9_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
        train_start && draining |=> seq_err);

    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $past(train_start));

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= CNT_W'(DEPTH));

    a_r7_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> hit_count == CNT_W'(DEPTH));

    a_r4_bx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !acq && !train_start |=> $stable(bx_cnt));

    a_r6_quiet_in_train: assert property (@(posedge clk) disable iff (!rst_n)
        acq |-> !out_valid);
endmodule

bind sthit_store sthit_store_chk #(
    .DEPTH(DEPTH), .BX_W(BX_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
) i_chk (.*);

// File: tb/test_sthit_store.sv
module test_sthit_store;
    localparam int NPADS = 4, AMP_W = 10, BX_W = 12, DEPTH = 64;
    localparam int WORD_W = 26;

    logic clk = 1'b0, rst_n = 1'b0;
    logic train_start = 0, train_stop = 0, bx_strobe = 0, rd_req = 0, out_ready = 1;
    logic [NPADS*AMP_W-1:0] pad_amps = '0;
    logic [AMP_W-1:0] thresh = '0;
    logic out_valid, seq_err;
    logic [WORD_W-1:0] out_data;

    sthit_store i_sthit_store (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0, bxn = 0;
    logic [WORD_W-1:0] exp_q[$];
    string tag_q[$];
    logic [23:0] hits_m[$];
    logic ovf_m = 0;
    bit slow = 0;
    logic [7:0] lfsr = 8'hA5;
    bit pend = 0;
    logic [WORD_W-1:0] prev_w;

    task automatic chk(input bit ok, input string req, input logic [WORD_W-1:0] act, exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Ready pattern, driven just after each edge.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = slow ? lfsr[0] : 1'b1;
    end

    // Monitor / scoreboard: compare accepted words, check holding (R8).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (pend) chk(out_data == prev_w, "R8", out_data, prev_w);
            if (out_ready) begin
                if (exp_q.size() == 0) chk(0, "R5", out_data, '0);
                else begin
                    string t;
                    logic [WORD_W-1:0] e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(out_data == e, t, out_data, e);
                end
            end
            pend = !out_ready;
            prev_w = out_data;
        end else begin
            if (rst_n && pend) chk(0, "R8", {25'b0, out_valid}, 26'd1);
            pend = 0;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        train_start = 1; step(); train_start = 0;
    endtask

    task automatic open_train();
        pulse_start();
        bxn = 0; hits_m.delete(); ovf_m = 0;   // R10: fresh model
    endtask

    task automatic close_train();
        repeat (4) step();
        train_stop = 1; step(); train_stop = 0;
        repeat (2) step();
    endtask

    // One crossing; model keeps strictly-above samples (R2) tagged (R3, R4).
    task automatic crossing(input logic [9:0] a0, a1, a2, a3, input bit in_train);
        logic [9:0] a [4];
        a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
        pad_amps = {a3, a2, a1, a0};
        bx_strobe = 1; step(); bx_strobe = 0;
        if (in_train) begin
            for (int p = 0; p < 4; p++) begin
                if (a[p] > thresh) begin
                    if (hits_m.size() < DEPTH) hits_m.push_back({bxn[11:0], p[1:0], a[p]});
                    else ovf_m = 1;              // R7
                end
            end
            bxn++;
        end
        repeat (7) step();
    endtask

    task automatic drain(input bit poke);
        int guard;
        exp_q.push_back({2'b01, 24'(hits_m.size())}); tag_q.push_back("R5");
        foreach (hits_m[i]) begin exp_q.push_back({2'b00, hits_m[i]}); tag_q.push_back("R3"); end
        exp_q.push_back({2'b11, 23'b0, ovf_m}); tag_q.push_back(ovf_m ? "R7" : "R5");
        rd_req = 1; step(); rd_req = 0;
        if (poke) begin
            repeat (3) step();
            pulse_start();
            @(negedge clk);
            chk(seq_err == 1'b1, "R9", {25'b0, seq_err}, 26'd1);
            step();
        end
        guard = 0;
        while (exp_q.size() != 0 && guard < 5000) begin step(); guard++; end
        chk(exp_q.size() == 0, "R6", 26'(exp_q.size()), 26'd0);
        exp_q.delete(); tag_q.delete();
        repeat (2) step();
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", {25'b0, out_valid}, 26'd0);
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) step();
        @(negedge clk);
        chk(out_valid == 0, "R1", {25'b0, out_valid}, 26'd0);
        chk(seq_err == 0, "R1", {25'b0, seq_err}, 26'd0);
        step();
        rst_n = 1; step();
        @(negedge clk);
        chk(out_valid == 0 && seq_err == 0, "R1", {24'b0, out_valid, seq_err}, 26'd0);
        step();
        thresh = 10'd100;

        // R4: crossings outside a train are ignored.
        crossing(10'd200, 10'd200, 10'd200, 10'd200, 0);

        // Train A: mixed pads, equal-to-threshold dropped (R2).
        open_train();
        crossing(10'd150, 10'd50, 10'd100, 10'd101, 1);
        crossing(10'd0, 10'd0, 10'd0, 10'd0, 1);
        rd_req = 1; step(); rd_req = 0;                // R6: ignored in train
        repeat (3) step();
        @(negedge clk);
        chk(out_valid == 0, "R6", {25'b0, out_valid}, 26'd0);
        step();
        crossing(10'd10, 10'd300, 10'd20, 10'd1023, 1);
        close_train();
        drain(0);

        // R11: empty train.
        open_train();
        crossing(10'd1, 10'd2, 10'd3, 10'd100, 1);
        close_train();
        drain(0);

        // R7 overflow with back-pressure, and R9 poke during drain.
        slow = 1;
        open_train();
        for (int c = 0; c < 17; c++)
            crossing(10'(101 + c), 10'(200 + c), 10'(300 + c), 10'(400 + c), 1);
        close_train();
        drain(1);
        slow = 0;

        // R9: the poked train must not have started.
        crossing(10'd900, 10'd900, 10'd900, 10'd900, 0);
        train_stop = 1; step(); train_stop = 0;
        rd_req = 1; step(); rd_req = 0;
        repeat (4) step();
        @(negedge clk);
        chk(out_valid == 0, "R9", {25'b0, out_valid}, 26'd0);
        step();

        // R10: new train clears count and overflow.
        open_train();
        thresh = 10'd500;
        crossing(10'd600, 10'd499, 10'd500, 10'd501, 1);
        close_train();
        drain(0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule